// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is a purely combinational datapath element that transforms one n-bit operand. In its shift mode it either passes the operand through untouched or moves it by exactly one bit position toward the least or the most significant end. The freshly vacated bit is taken from a dedicated serial fill input, one for each direction. The operand's end bits, which are the bits lost on a one-place move, are always visible on two serial outputs. This lets several units be chained into a wider shifter, or lets a carry-style bit be captured by surrounding logic.

In its rotate mode the operand is rotated toward the most significant end by a binary amount of log2(n) bits. Every bit that leaves the top re-enters at the bottom. The rotator is a chain of stages. Each stage is a four-way multiplexer that moves the word by 0, 1, 2 or 3 times a stage step. The first stage has the coarsest step and the last stage has a step of one. This bounds the logic depth to log4(n) multiplexer levels. The width parameter must therefore be a power of four.

The unit has no state. The house style's state-machine layout does not apply here. Its choices are held in two enumerated selectors: mode `MODE_SHIFT`/`MODE_ROTATE` and shift code `SEL_PASS`/`SEL_RIGHT`/`SEL_LEFT`/`SEL_SPARE`. There are no transitions.

Top module: `shrot_unit`

## Requirements
- R1: With `mode`=0 (shift) and `shift_sel`=2'b00, `data_h` equals `data_b`.
- R2: With `mode`=0 and `shift_sel`=2'b01, `data_h[WIDTH-1]` equals `fill_msb` and `data_h[i]` equals `data_b[i+1]` for every lower bit i.
- R3: With `mode`=0 and `shift_sel`=2'b10, `data_h[0]` equals `fill_lsb` and `data_h[i]` equals `data_b[i-1]` for every higher bit i.
- R4: With `mode`=0 and the spare code `shift_sel`=2'b11, `data_h` equals `data_b`.
- R5: `drop_lsb` always equals `data_b[0]` and `drop_msb` always equals `data_b[WIDTH-1]`, in every mode.
- R6: With `mode`=1 (rotate), bit i of `data_b` appears at `data_h[(i+rot_amt) mod WIDTH]`, a left rotate by `rot_amt` places.
- R7: With `mode`=1 and `rot_amt`=0, `data_h` equals `data_b`.
- R8: With `mode`=1, `shift_sel`, `fill_msb` and `fill_lsb` have no effect on `data_h`.
- R9: With `mode`=0, `rot_amt` has no effect on `data_h`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_b | input | WIDTH | Operand |
| mode | input | 1 | 0 = one-place shift path, 1 = rotate path |
| shift_sel | input | 2 | 00 pass, 01 toward LSB, 10 toward MSB, 11 spare (pass) |
| fill_msb | input | 1 | Bit entering the MSB on a move toward the LSB |
| fill_lsb | input | 1 | Bit entering the LSB on a move toward the MSB |
| rot_amt | input | log2(WIDTH) | Left-rotate distance |
| data_h | output | WIDTH | Result |
| drop_lsb | output | 1 | Bit lost on a move toward the LSB (operand LSB) |
| drop_msb | output | 1 | Bit lost on a move toward the MSB (operand MSB) |

## Verification
The bench builds the unit at its default width of 16. This gives a two-stage rotator with a 4-bit amount. The whole amount range, 0 to 15, can be swept directly, so both the coarse stage (steps of 4) and the fine stage (steps of 1) are exercised in every combination. Random operands are mixed with directed all-ones, single-bit and end-bit patterns. Unused inputs are toggled between paired applications to expose any leakage between the shift and rotate paths.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic {
        MODE_SHIFT  = 1'b0,
        MODE_ROTATE = 1'b1
    } shrot_mode_e;

    typedef enum logic [1:0] {
        SEL_PASS  = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_LEFT  = 2'b10,
        SEL_SPARE = 2'b11
    } shift_sel_e;

endpackage

// File: rtl/shrot_step1.sv
module shrot_step1
    import shrot_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_in,
    input  shift_sel_e       sel,
    input  logic             fill_hi,
    input  logic             fill_lo,
    output logic [WIDTH-1:0] s_out
);

    always_comb begin
        unique case (sel)
            SEL_RIGHT: s_out = {fill_hi, b_in[WIDTH-1:1]};
            SEL_LEFT:  s_out = {b_in[WIDTH-2:0], fill_lo};
            SEL_PASS,
            SEL_SPARE: s_out = b_in;
            default:   s_out = b_in;
        endcase
    end

    always_comb begin
        // R2
        if (sel == SEL_RIGHT) begin
            right_fill_chk: assert (s_out[WIDTH-1] == fill_hi && s_out[0] == b_in[1]);
        end
        // R3
        if (sel == SEL_LEFT) begin
            left_fill_chk: assert (s_out[0] == fill_lo && s_out[WIDTH-1] == b_in[WIDTH-2]);
        end
    end

endmodule

// File: rtl/shrot_rot_stage.sv
module shrot_rot_stage #(
    parameter int WIDTH = 16,
    parameter int STEP  = 4
) (
    input  logic [WIDTH-1:0] r_in,
    input  logic [1:0]       pick,
    output logic [WIDTH-1:0] r_out
);

    localparam int STEP2 = 2 * STEP;
    localparam int STEP3 = 3 * STEP;

    function automatic logic [WIDTH-1:0] rotl(input logic [WIDTH-1:0] v,
                                              input int unsigned k);
        logic [2*WIDTH-1:0] dbl;
        dbl = {v, v} << k;
        return dbl[2*WIDTH-1:WIDTH];
    endfunction

    always_comb begin
        unique case (pick)
            2'd0: r_out = r_in;
            2'd1: r_out = rotl(r_in, STEP);
            2'd2: r_out = rotl(r_in, STEP2);
            2'd3: r_out = rotl(r_in, STEP3);
            default: r_out = r_in;
        endcase
    end

    always_comb begin
        // R6
        ones_kept_chk: assert ($countones(r_out) == $countones(r_in));
        // R6
        lsb_moved_chk: assert (r_out[(32'(pick) * STEP) % WIDTH] == r_in[0]);
    end

endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]         r_in,
    input  logic [$clog2(WIDTH)-1:0] amt,
    output logic [WIDTH-1:0]         r_out
);

    localparam int AW     = $clog2(WIDTH);
    localparam int STAGES = AW / 2;

    logic [WIDTH-1:0] lvl [STAGES+1];

    assign lvl[0] = r_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int STEP = WIDTH >> (2 * (s + 1));
        shrot_rot_stage #(
            .WIDTH (WIDTH),
            .STEP  (STEP)
        ) u_stage (
            .r_in  (lvl[s]),
            .pick  (amt[AW-1-2*s -: 2]),
            .r_out (lvl[s+1])
        );
    end

    assign r_out = lvl[STAGES];

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_b,
    input  logic             mode,
    input  logic [1:0]       shift_sel,
    input  logic             fill_msb,
    input  logic             fill_lsb,
    input  logic [AW-1:0]    rot_amt,
    output logic [WIDTH-1:0] data_h,
    output logic             drop_lsb,
    output logic             drop_msb
);

    shrot_mode_e      mode_q;
    shift_sel_e       sel_q;
    logic [WIDTH-1:0] shift_res;
    logic [WIDTH-1:0] rot_res;

    assign mode_q = shrot_mode_e'(mode);
    assign sel_q  = shift_sel_e'(shift_sel);

    shrot_step1 #(.WIDTH(WIDTH)) u_step (
        .b_in    (data_b),
        .sel     (sel_q),
        .fill_hi (fill_msb),
        .fill_lo (fill_lsb),
        .s_out   (shift_res)
    );

    shrot_rotator #(.WIDTH(WIDTH)) u_rot (
        .r_in  (data_b),
        .amt   (rot_amt),
        .r_out (rot_res)
    );

    always_comb begin
        unique case (mode_q)
            MODE_ROTATE: data_h = rot_res;
            MODE_SHIFT:  data_h = shift_res;
            default:     data_h = shift_res;
        endcase
    end

    assign drop_lsb = data_b[0];
    assign drop_msb = data_b[WIDTH-1];

    always_comb begin
        // R4
        if (mode_q == MODE_SHIFT && sel_q == SEL_SPARE) begin
            spare_pass_chk: assert (data_h == data_b);
        end
        // R1
        if (mode_q == MODE_SHIFT && sel_q == SEL_PASS) begin
            pass_chk: assert (data_h == data_b);
        end
        // R7
        if (mode_q == MODE_ROTATE && rot_amt == '0) begin
            zero_rot_chk: assert (data_h == data_b);
        end
        // R6
        if (mode_q == MODE_ROTATE) begin
            rot_ones_chk: assert ($countones(data_h) == $countones(data_b));
        end
    end

endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;

    localparam int W  = 16;
    localparam int AW = $clog2(W);

    logic          clk = 1'b0;
    logic [W-1:0]  data_b;
    logic          mode;
    logic [1:0]    shift_sel;
    logic          fill_msb, fill_lsb;
    logic [AW-1:0] rot_amt;
    logic [W-1:0]  data_h;
    logic          drop_lsb, drop_msb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    shrot_unit #(.WIDTH(W)) u0 (
        .data_b    (data_b),
        .mode      (mode),
        .shift_sel (shift_sel),
        .fill_msb  (fill_msb),
        .fill_lsb  (fill_lsb),
        .rot_amt   (rot_amt),
        .data_h    (data_h),
        .drop_lsb  (drop_lsb),
        .drop_msb  (drop_msb)
    );

    function automatic logic [W-1:0] ref_out(input logic [W-1:0] b, input logic m,
                                             input logic [1:0] s, input logic fm,
                                             input logic fl, input logic [AW-1:0] a);
        logic [W-1:0] r;
        r = b;
        if (m) begin
            for (int i = 0; i < W; i++) r[(i + int'(a)) % W] = b[i];
        end else if (s == 2'b01) begin
            for (int i = 0; i < W-1; i++) r[i] = b[i+1];
            r[W-1] = fm;
        end else if (s == 2'b10) begin
            for (int i = 1; i < W; i++) r[i] = b[i-1];
            r[0] = fl;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic m, input logic [1:0] s,
                                     input logic [AW-1:0] a);
        if (m) return (a == 0) ? "R7" : "R6";
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] b, input logic m, input logic [1:0] s,
                         input logic fm, input logic fl, input logic [AW-1:0] a);
        @(posedge clk);
        data_b = b; mode = m; shift_sel = s; fill_msb = fm; fill_lsb = fl; rot_amt = a;
        @(negedge clk);
        check(tag_of(m, s, a), data_h, ref_out(b, m, s, fm, fl, a));
        // R5 serial outputs follow the operand's end bits
        check("R5", {{(W-2){1'b0}}, drop_msb, drop_lsb}, {{(W-2){1'b0}}, b[W-1], b[0]});
    endtask

    initial begin
        data_b = '0; mode = 1'b0; shift_sel = 2'b00;
        fill_msb = 1'b0; fill_lsb = 1'b0; rot_amt = '0;
        void'($urandom(32'd4242));
        @(negedge clk);
        check("R1", data_h, '0);

        apply(16'hA5C3, 1'b0, 2'b00, 1'b1, 1'b1, 4'd7);
        apply(16'h8001, 1'b0, 2'b01, 1'b1, 1'b0, 4'd0);
        apply(16'h8001, 1'b0, 2'b01, 1'b0, 1'b1, 4'd0);
        apply(16'h8001, 1'b0, 2'b10, 1'b0, 1'b1, 4'd0);
        apply(16'h8001, 1'b0, 2'b10, 1'b1, 1'b0, 4'd0);
        apply(16'hFFFF, 1'b0, 2'b11, 1'b0, 1'b0, 4'd3);
        apply(16'h1234, 1'b0, 2'b11, 1'b1, 1'b1, 4'd15);
        for (int a = 0; a < W; a++) begin
            apply(16'h0001, 1'b1, 2'b00, 1'b0, 1'b0, AW'(a));
            apply(16'hC0DE, 1'b1, 2'b11, 1'b1, 1'b1, AW'(a));
        end

        // R8 rotate path ignores select code and fill inputs
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0]  b;
            logic [AW-1:0] a;
            b = W'($urandom);
            a = AW'($urandom);
            apply(b, 1'b1, 2'(k), k[2], ~k[2], a);
            check("R8", data_h, ref_out(b, 1'b1, 2'b00, 1'b0, 1'b0, a));
        end
        // R9 shift path ignores the rotate amount
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] b;
            b = W'($urandom);
            apply(b, 1'b0, 2'(k), 1'b1, 1'b0, AW'(k * 5 + 1));
            check("R9", data_h, ref_out(b, 1'b0, 2'(k), 1'b1, 1'b0, '0));
        end

        for (int k = 0; k < 400; k++) begin
            apply(W'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), AW'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule